// File: doc/BRIEF.md
# Sliding DFT Bin Filter Bank

This block filters a stream of signed Q1.15 samples in the frequency domain without running a full transform. For each incoming sample it updates a contiguous range of sliding-DFT bins, from a programmed first bin to a programmed last bin. Each bin is a damped complex resonator, so it cannot ring forever. When all selected bins have been updated, the block forms one output sample as a signed sum of their real parts. The two edge bins carry half weight and the interior bins alternate in sign. The effect is a band-pass filter whose pass band is set by the chosen bin range.

The frame length is a power of two, from 32 up to a parameter-set maximum. Rotation factors come from a cosine table that is computed at elaboration. A single complex multiply-accumulate visits the bins one per clock, and input ready stays low until the pass is finished. Changing the frame length, the bin range or the damping factor restarts the block. The restart clears every bin and the window history. No output is produced until a full window of new samples has arrived.

Top module: `sdft_bank`

## Requirements
- R1: After a sample is accepted (in_valid and in_ready both high at a rising edge), in_ready stays low for exactly L clock cycles, where L = stop - start + 1, and is high again in the cycle after those L cycles.
- R2: out_valid is a one-cycle pulse, raised in the cycle that follows the L-th rising edge after the accepting edge. That is the same cycle in which in_ready returns high.
- R3: For every bin k with start <= k <= stop, each accepted sample x updates the bin as X_k <- r * e^(j*2*pi*k/N) * (X_k + x - r^N * x_old). Here r = cfg_damp / 32768, and x_old is the sample accepted N samples earlier. Bins outside the range have no influence on the output.
- R4: Until N samples have been accepted since the last restart, x_old is taken as zero. r^N is formed by squaring r log2(N) times during restart.
- R5: The output is the saturated sum of w_i * Re(X), with i = k - start. The weight is w_i = -1 for even i and +1 for odd i, halved for i = 0 and for k = stop. A single-bin range gives weight -0.5.
- R6: Counting from a restart, the first N-1 accepted samples produce no out_valid pulse. Every sample from the N-th onward produces exactly one pulse.
- R7: Any change of cfg_log2n, cfg_start, cfg_stop or cfg_damp restarts the block. in_ready goes low in the next cycle, all bins and the window history are cleared, and in_ready does not return before the power r^N is ready.
- R8: A configuration is served only if 5 <= cfg_log2n <= LG_MAX, start <= stop < N and stop - start < MAX_BINS. Otherwise in_ready stays low.
- R9: Bin components and the output saturate to the Q1.15 range [-32768, 32767] instead of wrapping.
- R10: During reset and in the first cycle after it, out_valid and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DW | Input sample, signed Q1.15 |
| cfg_log2n | input | 4 | log2 of the frame length N |
| cfg_start | input | LG_MAX | First selected bin |
| cfg_stop | input | LG_MAX | Last selected bin |
| cfg_damp | input | DW-1 | Damping factor r, unsigned Q0.15 |
| out_valid | output | 1 | One-cycle strobe for out_data |
| out_data | output | DW | Reconstructed sample, signed Q1.15 |

## Verification
Some properties are checked on every clock cycle. in_ready drops after each accepted sample. out_valid is a single-cycle pulse that only follows a bin pass. It never appears before a full window has been absorbed, and it never appears in the cycle after a configuration change. The bin counter stays inside the programmed range. The numerical behaviour can only be shown by the bench scenarios, which compare each output against a floating-point model of the damped recurrence and the alternating weights. These scenarios cover the exact ready and valid latency, the warm-up length, clearing on restart, saturation under a large constant input, and refusal of malformed configurations.

// File: rtl/sdft_bank.sv
module sdft_bank #(
  parameter int DW       = 16,
  parameter int LG_MAX   = 11,
  parameter int MIN_LG   = 5,
  parameter int MAX_BINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic signed [DW-1:0]  in_data,
  input  logic [3:0]            cfg_log2n,
  input  logic [LG_MAX-1:0]     cfg_start,
  input  logic [LG_MAX-1:0]     cfg_stop,
  input  logic [DW-2:0]         cfg_damp,
  output logic                  out_valid,
  output logic signed [DW-1:0]  out_data
);

  localparam int MAXN = 1 << LG_MAX;
  localparam int BW   = (MAX_BINS > 1) ? $clog2(MAX_BINS) : 1;
  localparam int SW   = 2*DW + 4;
  localparam int FB   = DW - 1;
  localparam int RNDI = 1 << (FB-1);
  localparam logic signed [SW-1:0] RND  = SW'(RNDI);
  localparam logic signed [SW-1:0] QMAX = SW'((1 << FB) - 1);
  localparam logic signed [SW-1:0] QMIN = SW'(-(1 << FB));
  localparam real SCL = (2.0 ** FB) - 1.0;
  localparam real PI2 = 6.283185307179586;

  typedef enum logic [1:0] {S_RST, S_PREP, S_IDLE, S_BUSY} st_t;

  function automatic logic signed [DW-1:0] sat(input logic signed [SW-1:0] v);
    if (v > QMAX)      return DW'(QMAX);
    else if (v < QMIN) return DW'(QMIN);
    else               return DW'(v);
  endfunction

  logic signed [DW-1:0] cos_tab [MAXN];
  for (genvar g = 0; g < MAXN; g++) begin : g_tw
    localparam real CR = SCL * $cos(PI2 * g / MAXN);
    localparam int  CV = (CR >= 0.0) ? $rtoi(CR + 0.5) : $rtoi(CR - 0.5);
    assign cos_tab[g] = DW'(CV);
  end

  st_t                  state;
  logic [3:0]           lg_q, pcnt;
  logic [LG_MAX-1:0]    st_q, sp_q, ptr, k;
  logic [DW-2:0]        dm_q, rpow;
  logic [LG_MAX:0]      fill;
  logic                 emit_q;
  logic [BW-1:0]        j;
  logic signed [DW-1:0] d_q;
  logic signed [SW-1:0] acc;
  logic signed [DW-1:0] bin_re [MAX_BINS];
  logic signed [DW-1:0] bin_im [MAX_BINS];
  logic signed [DW-1:0] dly    [MAXN];

  logic cfg_chg, cfg_ok, fire, full;
  logic [LG_MAX:0]   n_full;
  logic [LG_MAX-1:0] n_mask, span;

  assign cfg_chg = (cfg_log2n != lg_q) || (cfg_start != st_q) ||
                   (cfg_stop != sp_q) || (cfg_damp != dm_q);
  assign n_full  = (LG_MAX+1)'(1) << lg_q;
  assign n_mask  = LG_MAX'(n_full - 1'b1);
  assign span    = sp_q - st_q;
  assign cfg_ok  = (lg_q >= 4'(MIN_LG)) && (lg_q <= 4'(LG_MAX)) && (sp_q >= st_q) &&
                   (span < LG_MAX'(MAX_BINS)) && ({1'b0, sp_q} < n_full);
  assign in_ready = (state == S_IDLE) && !cfg_chg && cfg_ok;
  assign fire     = in_valid && in_ready;
  assign full     = (fill == n_full);

  // sample leaving the window, scaled by r^N
  logic signed [DW-1:0] x_old, d_nx;
  logic signed [SW-1:0] old_p;
  assign x_old = full ? dly[ptr] : '0;
  assign old_p = SW'($signed({1'b0, rpow})) * SW'(x_old);
  assign d_nx  = sat(SW'(in_data) - ((old_p + RND) >>> FB));

  logic [2*DW-3:0] rsq_p;
  logic [DW-2:0]   rsq;
  assign rsq_p = rpow * rpow;
  assign rsq   = (DW-1)'((rsq_p + (2*DW-2)'(RNDI)) >> FB);

  // damped rotation for bin k
  logic [3:0]           sh;
  logic [LG_MAX-1:0]    tw_i, sn_i;
  logic signed [SW-1:0] dmp, wr_p, wi_p, a_s, b_s;
  logic signed [DW-1:0] wr, wi, nre, nim;
  assign sh   = 4'(LG_MAX) - lg_q;
  assign tw_i = k << sh;
  assign sn_i = tw_i - LG_MAX'(MAXN/4);
  assign dmp  = SW'($signed({1'b0, dm_q}));
  assign wr_p = (dmp * SW'(cos_tab[tw_i]) + RND) >>> FB;
  assign wi_p = (dmp * SW'(cos_tab[sn_i]) + RND) >>> FB;
  assign wr   = DW'(wr_p);
  assign wi   = DW'(wi_p);
  assign a_s  = SW'(bin_re[j]) + SW'(d_q);
  assign b_s  = SW'(bin_im[j]);
  assign nre  = sat((a_s*SW'(wr) - b_s*SW'(wi) + RND) >>> FB);
  assign nim  = sat((a_s*SW'(wi) + b_s*SW'(wr) + RND) >>> FB);

  // alternating-sign reconstruction, half weight at both edges (acc in half units)
  logic                 edge_b, last_b;
  logic signed [SW-1:0] mag, term, acc_nx;
  assign last_b = (k == sp_q);
  assign edge_b = (j == '0) || last_b;
  assign mag    = edge_b ? SW'(nre) : (SW'(nre) <<< 1);
  assign term   = j[0] ? mag : -mag;
  assign acc_nx = ((j == '0) ? '0 : acc) + term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RST;
      lg_q <= '0; st_q <= '0; sp_q <= '0; dm_q <= '0;
      rpow <= '0; pcnt <= '0; fill <= '0; ptr <= '0;
      emit_q <= 1'b0; k <= '0; j <= '0; d_q <= '0; acc <= '0;
      out_valid <= 1'b0; out_data <= '0;
      for (int i = 0; i < MAX_BINS; i++) begin
        bin_re[i] <= '0;
        bin_im[i] <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      if (state == S_RST) begin
        lg_q <= cfg_log2n; st_q <= cfg_start; sp_q <= cfg_stop; dm_q <= cfg_damp;
        rpow <= cfg_damp; pcnt <= '0; fill <= '0; ptr <= '0;
        for (int i = 0; i < MAX_BINS; i++) begin
          bin_re[i] <= '0;
          bin_im[i] <= '0;
        end
        state <= S_PREP;
      end else if (cfg_chg) begin
        state <= S_RST;
      end else begin
        case (state)
          S_PREP: begin
            if (pcnt == lg_q) state <= S_IDLE;
            else begin
              rpow <= rsq;
              pcnt <= pcnt + 1'b1;
            end
          end
          S_IDLE: if (fire) begin
            d_q    <= d_nx;
            ptr    <= (ptr + 1'b1) & n_mask;
            emit_q <= (fill + 1'b1 >= n_full);
            if (!full) fill <= fill + 1'b1;
            k <= st_q;
            j <= '0;
            state <= S_BUSY;
          end
          S_BUSY: begin
            bin_re[j] <= nre;
            bin_im[j] <= nim;
            acc <= acc_nx;
            if (last_b) begin
              out_valid <= emit_q;
              out_data  <= sat(acc_nx >>> 1);
              state <= S_IDLE;
            end else begin
              k <= k + 1'b1;
              j <= j + 1'b1;
            end
          end
          default: state <= S_RST;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire) dly[ptr] <= in_data;
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !in_ready);
  a_r2_valid_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(state == S_BUSY));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r6_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> full);
  a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && state != S_RST) |=> (!out_valid && !in_ready));
  a_r3_bin_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY) |-> (k >= st_q && k <= sp_q));

endmodule

// File: tb/sdft_bank_tb_top.sv
module sdft_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, LG_MAX = 11, MAX_BINS = 32;
  localparam int TOL = 80;
  localparam real PI2 = 6.283185307179586;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic [3:0] cfg_log2n = 4'd5;
  logic [LG_MAX-1:0] cfg_start = '0, cfg_stop = '0;
  logic [DW-2:0] cfg_damp = 15'd29491;
  logic in_ready, out_valid;
  logic signed [DW-1:0] out_data;

  sdft_bank #(.DW(DW), .LG_MAX(LG_MAX), .MIN_LG(5), .MAX_BINS(MAX_BINS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_log2n(cfg_log2n), .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_damp(cfg_damp),
    .out_valid(out_valid), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // floating-point reference of the requirements
  real mr[64], mi[64], hist[1024];
  real m_r, m_rn;
  int  m_n, m_st, m_sp, m_cnt;

  function automatic real clampq(input real v);
    if (v > 32767.0/32768.0) return 32767.0/32768.0;
    if (v < -1.0) return -1.0;
    return v;
  endfunction

  task automatic model_reset(input int lg, input int st, input int sp, input int dmp);
    m_n = 1 << lg; m_st = st; m_sp = sp; m_cnt = 0;
    m_r = dmp / 32768.0; m_rn = m_r ** m_n;
    for (int i = 0; i < 64; i++) begin mr[i] = 0.0; mi[i] = 0.0; end
  endtask

  task automatic model_step(input int x, output bit ev, output int eo);
    real xn, xo, ar, nr, ni, ang, acc, w;
    xn = x / 32768.0;
    xo = (m_cnt >= m_n) ? hist[m_cnt - m_n] : 0.0;
    hist[m_cnt] = xn;
    m_cnt++;
    acc = 0.0;
    for (int k = m_st; k <= m_sp; k++) begin
      int i = k - m_st;
      ang = PI2 * k / m_n;
      ar = mr[i] + xn - m_rn * xo;
      nr = clampq(m_r * (ar * $cos(ang) - mi[i] * $sin(ang)));
      ni = clampq(m_r * (ar * $sin(ang) + mi[i] * $cos(ang)));
      mr[i] = nr; mi[i] = ni;
      w = (i % 2 == 0) ? -1.0 : 1.0;
      if (i == 0 || k == m_sp) w = w * 0.5;
      acc = acc + w * nr;
    end
    ev = (m_cnt >= m_n);
    eo = $rtoi(clampq(acc) * 32768.0);
  endtask

  function automatic int stim(input int p, input int n, input int lg);
    case (p)
      0: return $rtoi(1200.0 * $cos(PI2 * 2 * n / (1 << lg)));
      1: return 600;
      2: return ((n / 4) % 2 == 1) ? 900 : -900;
      default: return ((n*37 + 11) * (n*13 + 7)) % 2001 - 1000;
    endcase
  endfunction

  // send one sample; checks ready/valid timing (R1, R2, R6) and data (R3, R5, R9)
  task automatic send(input int x, input string req);
    int L, vat, rat, vcnt, got, waitc, eo;
    bit ev;
    L = m_sp - m_st + 1;
    waitc = 0;
    while (!in_ready && waitc < 200) begin @(negedge clk); waitc++; end
    in_valid = 1'b1; in_data = DW'(x);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    vat = 0; rat = 0; vcnt = 0; got = 0;
    for (int i = 1; i <= L + 2; i++) begin
      if (i > 1) @(negedge clk);
      if (out_valid) begin vcnt++; vat = i; got = out_data; end
      if (in_ready && rat == 0) rat = i;
    end
    model_step(x, ev, eo);
    check(rat == L + 1, "R1 ready return cycle", rat, L + 1);
    check(vat == (ev ? L + 1 : 0) && vcnt == (ev ? 1 : 0),
          {"R2/R6 valid pulse ", req}, vat, ev ? L + 1 : 0);
    if (ev) check(got - eo <= TOL && eo - got <= TOL, {"R3/R5 output ", req}, got, eo);
  endtask

  task automatic apply_cfg(input int lg, input int st, input int sp, input int dmp);
    @(negedge clk);
    cfg_log2n = 4'(lg); cfg_start = LG_MAX'(st); cfg_stop = LG_MAX'(sp); cfg_damp = 15'(dmp);
    model_reset(lg, st, sp, dmp);
    @(negedge clk);
    check(!in_ready, "R7 ready low after config change", int'(in_ready), 0);
    for (int i = 0; i < lg; i++) begin
      @(negedge clk);
      check(!in_ready, "R7 ready low while r^N forms", int'(in_ready), 0);
    end
  endtask

  localparam int SCN [4][6] = '{
    '{5, 1, 3, 29491, 0, 90},
    '{5, 0, 0, 31130, 1, 60},
    '{6, 2, 9, 29491, 2, 120},
    '{5, 4, 11, 31130, 3, 90}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready, "R10 outputs low in reset", int'(out_valid | in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !in_ready, "R10 outputs low after reset", int'(out_valid | in_ready), 0);

    // table of scenarios; each row also restarts from cleared state (R7)
    for (int s = 0; s < 4; s++) begin
      apply_cfg(SCN[s][0], SCN[s][1], SCN[s][2], SCN[s][3]);
      for (int n = 0; n < SCN[s][5]; n++)
        send(stim(SCN[s][4], n, SCN[s][0]), $sformatf("scenario %0d", s));
    end

    // zero input keeps every output at zero (R3)
    apply_cfg(5, 0, 2, 29491);
    for (int n = 0; n < 40; n++) send(0, "zero input");
    check(out_data == 0, "R3 zero input gives zero", int'(out_data), 0);

    // restart by damping change mid-stream clears state and repeats warm-up (R7, R4, R6)
    apply_cfg(5, 1, 6, 29491);
    for (int n = 0; n < 40; n++) send(stim(3, n, 5), "before damp change");
    apply_cfg(5, 1, 6, 31130);
    for (int n = 0; n < 40; n++) send(stim(0, n, 5), "after damp change");

    // large DC into bin 0 drives the bin into saturation (R9)
    apply_cfg(5, 0, 0, 32440);
    for (int n = 0; n < 60; n++) send(30000, "R9 saturation");
    check(out_data >= -16384 && out_data <= -16383, "R9 saturated single-bin output",
          int'(out_data), -16384);

    // malformed configurations are refused (R8)
    for (int c = 0; c < 3; c++) begin
      int seen = 0;
      @(negedge clk);
      case (c)
        0: begin cfg_log2n = 4'd5; cfg_start = 11'd5; cfg_stop = 11'd3; end
        1: begin cfg_log2n = 4'd5; cfg_start = 11'd0; cfg_stop = 11'd40; end
        default: begin cfg_log2n = 4'd7; cfg_start = 11'd0; cfg_stop = 11'd40; end
      endcase
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (in_ready) seen++;
      end
      check(seen == 0, "R8 malformed config refused", seen, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule